// File: doc/BRIEF.md
# GPIO Interrupt Detect and Aggregate

This block watches up to 95 general-purpose pads for interrupt conditions and folds them into one interrupt request line. Each pad supplies its synchronized input level and three configuration bits. The first is a trigger-select bit: 0 selects edge mode and 1 selects level mode. The second is an invert bit. The third is an ownership bit: 1 gives the pad to software, and 0 reserves it for firmware. The block records each detected condition in a status bit. It combines each status bit with a per-pad enable bit. It raises `irq_out` while any pad has both bits set.

Status and enable bits are accessed as words of 32 pads. Pad `p` lives in word `p/32` at bit `p%32`. A one-cycle write port selects the status bank or the enable bank. A status write clears the bits written as 1. An enable write replaces the whole word. A combinational read port returns both banks of one word.

Two small state machines shape the timing:
- **Detector machine.** States `DET_WARMUP` and `DET_ARMED`. It moves from `DET_WARMUP` to `DET_ARMED` on the first clock after reset and stays in `DET_ARMED`. Edge detection is suppressed while the machine is in `DET_WARMUP`.
- **Request machine.** States `IRQ_QUIET` and `IRQ_RAISED`. It moves from `IRQ_QUIET` to `IRQ_RAISED` when any pad is pending. It moves from `IRQ_RAISED` back to `IRQ_QUIET` when none is pending. `irq_out` is high exactly in `IRQ_RAISED`.

Top module: `gpio_irq_agg`

## Requirements
- R1: With trigger-select 0 and invert 0, a low-to-high change of a pad level sets that pad's status bit on the clock edge where the new level is first sampled.
- R2: With trigger-select 0 and invert 1, a high-to-low change sets the status bit on the clock edge where the new level is first sampled.
- R3: With trigger-select 1 and invert 0, a low pad level sets the status bit on each clock edge. A clear written while the level is still low leaves the bit set.
- R4: With trigger-select 1 and invert 1, a high pad level sets the status bit on each clock edge. A clear written while the level is still high leaves the bit set.
- R5: Writing the status bank (`wr_bank`=0) clears exactly the bits written as 1 and leaves bits written as 0 unchanged. Writing all ones to every word clears all status.
- R6: When a status clear and a new event for the same pad fall on the same clock edge, the status bit stays set.
- R7: A pad whose ownership bit is 0 never sets its status bit, in any trigger mode.
- R8: The first sample after reset never produces an edge. A pad already high when reset is released does not set status in rising-edge mode.
- R9: `irq_out` is the OR over all pads of status AND enable, delayed by one register. It rises on the edge after a status bit of an enabled pad becomes set.
- R10: Writing the enable bank (`wr_bank`=1) replaces the enable word. A pad with status set and enable clear does not raise `irq_out`, and status still latches while the pad is disabled.
- R11: Bits of pads at or above 95 (word 2, bit 31) and word indices of 3 or more always read 0. Writes to them have no effect.
- R12: After reset, every status and enable bit is 0 and `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_level | input | 95 | Synchronized pad input levels |
| trig_level | input | 95 | Per-pad trigger select: 0 = edge, 1 = level |
| trig_inv | input | 95 | Per-pad invert bit |
| pad_owned | input | 95 | Per-pad ownership: 1 = software, 0 = firmware |
| wr_en | input | 1 | One-cycle write strobe |
| wr_bank | input | 1 | Write target: 0 = status (clear on 1), 1 = enable |
| wr_word | input | 2 | Word index of the write |
| wr_data | input | 32 | Write data |
| rd_word | input | 2 | Word index of the read |
| rd_status | output | 32 | Status bits of the selected word |
| rd_enable | output | 32 | Enable bits of the selected word |
| irq_out | output | 1 | Registered combined interrupt request |

## Verification
The hardest case to reach from the ports is the collision where a status clear and a fresh event for the same pad land on the same clock edge. To set it up, the bench first sets the bit with an edge and returns the pad to its idle level. It then drives the clear write and the new edge on the same falling clock edge, so both are sampled together. A second hard case is the edge suppression on the first sample after reset. The bench holds every pad high through reset in rising-edge mode, so a missing warm-up state would latch the stale reset value as an edge. A sweep over all 95 pads, rotating through the four trigger modes, confirms the word and bit placement of every pad.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Trigger mode formed as {trigger_select, invert}
    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_e;

    typedef enum logic {
        BANK_STATUS = 1'b0,
        BANK_ENABLE = 1'b1
    } bank_e;

    typedef enum logic {
        DET_WARMUP = 1'b0,
        DET_ARMED  = 1'b1
    } det_state_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    function automatic int unsigned word_count(input int unsigned pads, input int unsigned width);
        return (pads + width - 1) / width;
    endfunction

endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PADS = 95
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pad_level,
    input  logic [NUM_PADS-1:0] trig_level,
    input  logic [NUM_PADS-1:0] trig_inv,
    input  logic [NUM_PADS-1:0] pad_owned,
    output logic [NUM_PADS-1:0] event_hit
);

    det_state_e          state_q;
    det_state_e          state_d;
    logic [NUM_PADS-1:0] prev_q;
    logic                edges_ok;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DET_WARMUP;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: one warm-up cycle, then armed for good
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DET_WARMUP: state_d = DET_ARMED;
            DET_ARMED:  state_d = DET_ARMED;
            default:    state_d = DET_WARMUP;
        endcase
    end

    // Outputs of the machine
    always_comb begin
        edges_ok = 1'b0;
        unique case (state_q)
            DET_ARMED: edges_ok = 1'b1;
            default:   edges_ok = 1'b0;
        endcase
    end

    // One-cycle delayed copy of every pad level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= pad_level;
        end
    end

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        trig_e mode;
        logic  hit;

        always_comb begin
            mode = trig_e'({trig_level[p], trig_inv[p]});
            hit  = 1'b0;
            unique case (mode)
                TRIG_RISE: hit = edges_ok & ~prev_q[p] &  pad_level[p];
                TRIG_FALL: hit = edges_ok &  prev_q[p] & ~pad_level[p];
                TRIG_LOW:  hit = ~pad_level[p];
                TRIG_HIGH: hit =  pad_level[p];
                default:   hit = 1'b0;
            endcase
        end

        assign event_hit[p] = hit & pad_owned[p];
    end

endmodule

// File: rtl/gpio_irq_word.sv
module gpio_irq_word #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] bit_live,
    input  logic [WORD_W-1:0] event_bits,
    input  logic              clr_stb,
    input  logic              en_stb,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] status_q,
    output logic [WORD_W-1:0] enable_q,
    output logic              pending
);

    logic [WORD_W-1:0] clr_mask;
    logic [WORD_W-1:0] status_d;
    logic [WORD_W-1:0] enable_d;

    always_comb begin
        clr_mask = clr_stb ? wr_data : '0;
        // A new event outranks a clear on the same edge
        status_d = ((status_q & ~clr_mask) | event_bits) & bit_live;
        enable_d = en_stb ? (wr_data & bit_live) : enable_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= status_d;
            enable_q <= enable_d;
        end
    end

    assign pending = |(status_q & enable_q);

endmodule

// File: rtl/gpio_irq_fsm.sv
module gpio_irq_fsm
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pending,
    output logic irq_out
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_pending)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!any_pending) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_out = 1'b0;
        unique case (state_q)
            IRQ_RAISED: irq_out = 1'b1;
            default:    irq_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PADS  = 95,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned NUM_WORDS = word_count(NUM_PADS, WORD_W),
    parameter int unsigned IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pad_level,
    input  logic [NUM_PADS-1:0] trig_level,
    input  logic [NUM_PADS-1:0] trig_inv,
    input  logic [NUM_PADS-1:0] pad_owned,
    input  logic                wr_en,
    input  logic                wr_bank,
    input  logic [IDX_W-1:0]    wr_word,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [IDX_W-1:0]    rd_word,
    output logic [WORD_W-1:0]   rd_status,
    output logic [WORD_W-1:0]   rd_enable,
    output logic                irq_out
);

    localparam int unsigned TOTAL_BITS = NUM_WORDS * WORD_W;

    logic [NUM_PADS-1:0]   event_hit;
    logic [TOTAL_BITS-1:0] event_all;
    logic [TOTAL_BITS-1:0] live_all;
    logic [TOTAL_BITS-1:0] status_all;
    logic [TOTAL_BITS-1:0] enable_all;
    logic [NUM_WORDS-1:0]  word_pend;
    logic                  any_pending;

    gpio_irq_detect #(
        .NUM_PADS (NUM_PADS)
    ) detect_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pad_level  (pad_level),
        .trig_level (trig_level),
        .trig_inv   (trig_inv),
        .pad_owned  (pad_owned),
        .event_hit  (event_hit)
    );

    // Pad vectors stretched to whole words; missing pads tie to zero
    for (genvar b = 0; b < TOTAL_BITS; b++) begin : g_bit
        if (b < NUM_PADS) begin : g_real
            assign event_all[b] = event_hit[b];
            assign live_all[b]  = 1'b1;
        end else begin : g_void
            assign event_all[b] = 1'b0;
            assign live_all[b]  = 1'b0;
        end
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic clr_stb;
        logic en_stb;

        assign clr_stb = wr_en && (wr_bank == BANK_STATUS) && (wr_word == IDX_W'(w));
        assign en_stb  = wr_en && (wr_bank == BANK_ENABLE) && (wr_word == IDX_W'(w));

        gpio_irq_word #(
            .WORD_W (WORD_W)
        ) word_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .bit_live   (live_all[w*WORD_W +: WORD_W]),
            .event_bits (event_all[w*WORD_W +: WORD_W]),
            .clr_stb    (clr_stb),
            .en_stb     (en_stb),
            .wr_data    (wr_data),
            .status_q   (status_all[w*WORD_W +: WORD_W]),
            .enable_q   (enable_all[w*WORD_W +: WORD_W]),
            .pending    (word_pend[w])
        );
    end

    assign any_pending = |word_pend;

    gpio_irq_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_pending (any_pending),
        .irq_out     (irq_out)
    );

    // Read mux; indices past the last word return zero
    always_comb begin
        rd_status = '0;
        rd_enable = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (rd_word == IDX_W'(i)) begin
                rd_status = status_all[i*WORD_W +: WORD_W];
                rd_enable = enable_all[i*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/gpio_irq_agg_chk.sv
module gpio_irq_agg_chk #(
    parameter int unsigned NUM_PADS  = 95,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned NUM_WORDS = (NUM_PADS + WORD_W - 1) / WORD_W,
    parameter int unsigned IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_PADS-1:0]           pad_owned,
    input logic                          wr_en,
    input logic                          wr_bank,
    input logic [IDX_W-1:0]              wr_word,
    input logic [WORD_W-1:0]             wr_data,
    input logic [IDX_W-1:0]              rd_word,
    input logic [WORD_W-1:0]             rd_status,
    input logic [WORD_W-1:0]             rd_enable,
    input logic [NUM_WORDS*WORD_W-1:0]   status_all,
    input logic [NUM_WORDS*WORD_W-1:0]   enable_all,
    input logic                          irq_out
);

    localparam int unsigned TOTAL_BITS = NUM_WORDS * WORD_W;

    logic [TOTAL_BITS-1:0] clr_ext;
    logic [TOTAL_BITS-1:0] owned_ext;
    logic                  any_pend;

    always_comb begin
        clr_ext   = '0;
        owned_ext = '0;
        owned_ext[NUM_PADS-1:0] = pad_owned;
        if (wr_en && !wr_bank) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (wr_word == IDX_W'(i)) begin
                    clr_ext[i*WORD_W +: WORD_W] = wr_data;
                end
            end
        end
    end

    assign any_pend = |(status_all & enable_all);

    // R9: request line is the registered OR of pending pads
    assert_irq_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(any_pend));

    // R7: newly set status bits belong only to software-owned pads
    assert_owned_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status_all & ~$past(status_all) & ~$past(owned_ext)) == '0));

    // R5: a status bit only drops where a 1 was written to it
    assert_clear_only_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(status_all) & ~status_all & ~$past(clr_ext)) == '0));

    // R11: reads past the last word return zero
    assert_void_word_reads_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_word) >= int'(NUM_WORDS)) |-> (rd_status == '0 && rd_enable == '0));

endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(
    .NUM_PADS (NUM_PADS),
    .WORD_W   (WORD_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pad_owned  (pad_owned),
    .wr_en      (wr_en),
    .wr_bank    (wr_bank),
    .wr_word    (wr_word),
    .wr_data    (wr_data),
    .rd_word    (rd_word),
    .rd_status  (rd_status),
    .rd_enable  (rd_enable),
    .status_all (status_all),
    .enable_all (enable_all),
    .irq_out    (irq_out)
);

// File: tb/gpio_irq_agg_tb_top.sv
module gpio_irq_agg_tb_top;

    localparam int NP = 95;
    localparam int NW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] pad_level, trig_level, trig_inv, pad_owned;
    logic          wr_en, wr_bank;
    logic [1:0]    wr_word, rd_word;
    logic [31:0]   wr_data, rd_status, rd_enable;
    logic          irq_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_irq_agg dut_i (
        .clk(clk), .rst_n(rst_n), .pad_level(pad_level), .trig_level(trig_level),
        .trig_inv(trig_inv), .pad_owned(pad_owned), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_word(wr_word), .wr_data(wr_data), .rd_word(rd_word), .rd_status(rd_status),
        .rd_enable(rd_enable), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_word(input int w, output logic [31:0] st, output logic [31:0] en);
        rd_word = 2'(w);
        #1;
        st = rd_status;
        en = rd_enable;
    endtask

    task automatic write_word(input bit bank, input int w, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_bank = bank;
        wr_word = 2'(w);
        wr_data = d;
        tick(1);
        wr_en   = 1'b0;
    endtask

    task automatic clear_all();
        for (int w = 0; w < NW; w++) write_word(1'b0, w, 32'hFFFF_FFFF);
    endtask

    function automatic logic [31:0] exp_bit(input int p, input int w);
        return (p / 32 == w) ? (32'd1 << (p % 32)) : 32'd0;
    endfunction

    task automatic set_mode(input bit sel, input bit inv);
        trig_level = {NP{sel}};
        trig_inv   = {NP{inv}};
    endtask

    // Every pad, trigger mode rotating with pad number
    task automatic run_sweep();
        logic [31:0] st, en;
        int m;
        bit sel, inv;
        string tag;
        for (int p = 0; p < NP; p++) begin
            m   = p % 4;
            sel = (m >= 2);
            inv = (m % 2) == 1;
            tag = (m == 0) ? "R1" : (m == 1) ? "R2" : (m == 2) ? "R3" : "R4";
            set_mode(sel, inv);
            pad_level = {NP{sel ^ inv}};
            tick(2);
            clear_all();
            pad_level[p] = ~(sel ^ inv);
            tick(1);
            for (int w = 0; w < NW; w++) begin
                read_word(w, st, en);
                check(tag, st, exp_bit(p, w));
            end
            write_word(1'b0, p / 32, 32'd1 << (p % 32));
            read_word(p / 32, st, en);
            check(sel ? tag : "R5", st, sel ? exp_bit(p, p / 32) : 32'd0);
            pad_level[p] = sel ^ inv;
            tick(1);
            clear_all();
            read_word(p / 32, st, en);
            check("R5", st, 32'd0);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] st, en;
        rst_n      = 1'b0;
        pad_level  = {NP{1'b1}};
        pad_owned  = {NP{1'b1}};
        set_mode(1'b0, 1'b0);
        wr_en = 1'b0; wr_bank = 1'b0; wr_word = '0; wr_data = '0; rd_word = '0;
        tick(3);
        rst_n = 1'b1;

        // R12: reset state
        for (int w = 0; w < NW; w++) begin
            read_word(w, st, en);
            check("R12 status", st, 32'd0);
            check("R12 enable", en, 32'd0);
        end
        check("R12 irq", {31'd0, irq_out}, 32'd0);

        // R8: pads high since reset, rising mode, no edge
        tick(3);
        for (int w = 0; w < NW; w++) begin
            read_word(w, st, en);
            check("R8", st, 32'd0);
        end

        run_sweep();

        // R7: unowned pads stay silent in level and edge modes
        pad_owned = '0;
        set_mode(1'b1, 1'b1);
        pad_level = '0;
        tick(2);
        clear_all();
        pad_level = {NP{1'b1}};
        tick(3);
        for (int w = 0; w < NW; w++) begin
            read_word(w, st, en);
            check("R7 level", st, 32'd0);
        end
        set_mode(1'b0, 1'b0);
        pad_level = '0;
        tick(1);
        pad_level = {NP{1'b1}};
        tick(1);
        for (int w = 0; w < NW; w++) begin
            read_word(w, st, en);
            check("R7 edge", st, 32'd0);
        end
        pad_owned = {NP{1'b1}};
        set_mode(1'b1, 1'b1);
        tick(1);
        read_word(0, st, en); check("R7 owned", st, 32'hFFFF_FFFF);
        read_word(1, st, en); check("R7 owned", st, 32'hFFFF_FFFF);
        read_word(2, st, en); check("R11 top bit", st, 32'h7FFF_FFFF);

        // R5: partial clear and write of zero
        set_mode(1'b0, 1'b0);
        pad_level = '0;
        tick(2);
        clear_all();
        pad_level[3] = 1'b1;
        pad_level[7] = 1'b1;
        tick(1);
        read_word(0, st, en); check("R5 set", st, 32'h88);
        write_word(1'b0, 0, 32'h0);
        read_word(0, st, en); check("R5 zero write", st, 32'h88);
        write_word(1'b1, 0, 32'h0);
        read_word(0, st, en); check("R5 enable write", st, 32'h88);
        write_word(1'b0, 0, 32'h08);
        read_word(0, st, en); check("R5 partial", st, 32'h80);

        // R6: clear and new edge on the same edge
        pad_level[7] = 1'b0;
        tick(1);
        pad_level[7] = 1'b1;
        write_word(1'b0, 0, 32'h80);
        read_word(0, st, en); check("R6 collision", st, 32'h80);
        write_word(1'b0, 0, 32'h80);
        read_word(0, st, en); check("R6 plain clear", st, 32'h0);

        // R9: request timing on pad 40 (word 1 bit 8)
        set_mode(1'b1, 1'b1);
        pad_level = '0;
        tick(2);
        clear_all();
        write_word(1'b1, 1, 32'h100);
        pad_level[40] = 1'b1;
        tick(1);
        read_word(1, st, en); check("R9 status", st, 32'h100);
        check("R9 irq lag", {31'd0, irq_out}, 32'd0);
        tick(1);
        check("R9 irq up", {31'd0, irq_out}, 32'd1);
        pad_level[40] = 1'b0;
        write_word(1'b0, 1, 32'h100);
        read_word(1, st, en); check("R9 cleared", st, 32'h0);
        check("R9 irq hold", {31'd0, irq_out}, 32'd1);
        tick(1);
        check("R9 irq down", {31'd0, irq_out}, 32'd0);

        // R10: disabled pad latches but does not raise the request
        write_word(1'b1, 1, 32'h0);
        pad_level[41] = 1'b1;
        tick(3);
        read_word(1, st, en); check("R10 latched", st, 32'h200);
        check("R10 masked", {31'd0, irq_out}, 32'd0);
        write_word(1'b1, 1, 32'h200);
        read_word(1, st, en); check("R10 enable", en, 32'h200);
        check("R10 lag", {31'd0, irq_out}, 32'd0);
        tick(1);
        check("R10 irq", {31'd0, irq_out}, 32'd1);
        pad_level[41] = 1'b0;
        write_word(1'b1, 1, 32'h0);
        clear_all();

        // R11: missing pad bits and missing word
        write_word(1'b1, 2, 32'hFFFF_FFFF);
        read_word(2, st, en); check("R11 enable top", en, 32'h7FFF_FFFF);
        write_word(1'b1, 3, 32'hFFFF_FFFF);
        read_word(3, st, en);
        check("R11 void status", st, 32'h0);
        check("R11 void enable", en, 32'h0);
        read_word(0, st, en); check("R11 no alias", en, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule